// File: doc/BRIEF.md
# Register-File LIFO Stack with Wrap-Around Pointer

This block is a last-in first-out store built from a small register file (64 words by default). A six-bit top pointer addresses the file and wraps modulo the depth, so every location holds data without an extra pointer bit. Two one-bit flags, full and empty, carry the information that the pointer alone cannot. Both flags are decided by the pointer landing on zero after an update. The direction of that update decides which flag is set.

A push advances the pointer first and then writes the incoming word at the new top. The first word therefore sits at location 1, and the last word of a full stack sits at location 0. A pop reads the word at the current top and then steps the pointer back. The popped word appears on a registered output one cycle later, marked by a valid strobe.

A push on a full stack, a pop on an empty stack, or both commands in one cycle is illegal. Such a command is refused and changes nothing, and it raises a one-cycle error pulse.

Top module: `lifo_regfile`

## Requirements
- R1: After reset, the pointer is 0, empty is 1, full is 0, and both the error and valid outputs are 0.
- R2: A legal push (push high, pop low, full low) changes the pointer to (pointer + 1) mod 64 and stores the word at the new pointer. The first push after reset gives pointer 1, and the 64th gives pointer 0.
- R3: After a legal push, full is 1 exactly when the new pointer is 0, and empty is 0.
- R4: A legal pop (pop high, push low, empty low) produces the word stored at the current pointer on rdata_o with rvalid_o high in the next cycle, and changes the pointer to (pointer − 1) mod 64.
- R5: After a legal pop, empty is 1 exactly when the new pointer is 0, and full is 0.
- R6: A push while full is 1 raises err_o for one cycle. It leaves the pointer, the flags and the stored words unchanged.
- R7: A pop while empty is 1 raises err_o for one cycle with rvalid_o low. It leaves the pointer and the flags unchanged.
- R8: Push and pop high in the same cycle raise err_o for one cycle. Nothing is stored or popped, and the pointer and flags are unchanged.
- R9: Words come out in the reverse of the order in which they were pushed, across the full depth.
- R10: In a cycle with no command, the pointer and flags hold, err_o and rvalid_o are 0, and full and empty are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push command for this cycle |
| pop_i | input | 1 | Pop command for this cycle |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Last popped word, registered |
| rvalid_o | output | 1 | One-cycle strobe: rdata_o holds a new popped word |
| err_o | output | 1 | One-cycle strobe: the previous command was refused |
| full_o | output | 1 | All locations hold data |
| empty_o | output | 1 | No location holds data |
| ptr_o | output | ADDR_W | Current top-of-stack pointer |

## Verification
The assertions assume that push_i and pop_i are sampled only at rising edges and are held stable across each edge. They make no assumption about command legality: illegal and simultaneous commands are checked, not excluded. The stimulus drives the commands on falling edges and returns them to zero after each command. It fills the stack to the wrap point, empties it completely, and tries every illegal form at both boundaries. This covers every antecedent of the assertions without relying on a restricted input pattern.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_POP  = 2'd2,
        CMD_BAD  = 2'd3
    } lifo_cmd_e;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              re_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o,
    output logic              rvalid_o
);

    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              full;
        logic              empty;
        logic              err;
        logic              rvalid;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    lifo_cmd_e   cmd;
    logic [ADDR_W-1:0] ptr_up, ptr_dn;

    always_comb begin
        ptr_up  = state_q.ptr + ONE;
        ptr_dn  = state_q.ptr - ONE;
        cmd     = CMD_IDLE;
        state_d = state_q;
        state_d.err    = 1'b0;
        state_d.rvalid = 1'b0;

        if (push_i && pop_i) begin
            cmd = CMD_BAD;
        end else if (push_i) begin
            cmd = state_q.full ? CMD_BAD : CMD_PUSH;
        end else if (pop_i) begin
            cmd = state_q.empty ? CMD_BAD : CMD_POP;
        end

        unique case (cmd)
            CMD_PUSH: begin
                state_d.ptr   = ptr_up;
                state_d.full  = (ptr_up == ZERO);
                state_d.empty = 1'b0;
            end
            CMD_POP: begin
                state_d.ptr    = ptr_dn;
                state_d.empty  = (ptr_dn == ZERO);
                state_d.full   = 1'b0;
                state_d.rvalid = 1'b1;
            end
            CMD_BAD: begin
                state_d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{ptr: ZERO, full: 1'b0, empty: 1'b1, err: 1'b0, rvalid: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign we_o     = (cmd == CMD_PUSH);
    assign waddr_o  = ptr_up;
    assign re_o     = (cmd == CMD_POP);
    assign raddr_o  = state_q.ptr;
    assign ptr_o    = state_q.ptr;
    assign full_o   = state_q.full;
    assign empty_o  = state_q.empty;
    assign err_o    = state_q.err;
    assign rvalid_o = state_q.rvalid;

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (we_i && (waddr_i == ADDR_W'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re_i) begin
            rdata_d = mem_q[raddr_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              err_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [ADDR_W-1:0] ptr_o
);

    logic              we, re;
    logic [ADDR_W-1:0] waddr, raddr;

    lifo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .we_o     (we),
        .waddr_o  (waddr),
        .re_o     (re),
        .raddr_o  (raddr),
        .ptr_o    (ptr_o),
        .full_o   (full_o),
        .empty_o  (empty_o),
        .err_o    (err_o),
        .rvalid_o (rvalid_o)
    );

    lifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata_i),
        .re_i    (re),
        .raddr_i (raddr),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/lifo_regfile_chk.sv
module lifo_regfile_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              push_i,
    input logic              pop_i,
    input logic              rvalid_o,
    input logic              err_o,
    input logic              full_o,
    input logic              empty_o,
    input logic [ADDR_W-1:0] ptr_o
);

    // R2
    push_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !full_o) |=> (ptr_o == ADDR_W'($past(ptr_o) + 1'b1)));

    // R3
    push_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !full_o) |=> (!empty_o && (full_o == (ptr_o == '0))));

    // R4
    pop_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && !empty_o) |=> (rvalid_o && (ptr_o == ADDR_W'($past(ptr_o) - 1'b1))));

    // R5
    pop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && !empty_o) |=> (!full_o && (empty_o == (ptr_o == '0))));

    // R6
    full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && full_o) |=> (err_o && full_o && $stable(ptr_o)));

    // R7
    empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && empty_o) |=> (err_o && !rvalid_o && empty_o && $stable(ptr_o)));

    // R8
    both_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i) |=> (err_o && !rvalid_o && $stable(ptr_o) && $stable(full_o) && $stable(empty_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!push_i && !pop_i) |=> (!err_o && !rvalid_o && $stable(ptr_o) && $stable(full_o)));

    // R10
    flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full_o && empty_o));

endmodule

bind lifo_regfile lifo_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .rvalid_o (rvalid_o),
    .err_o    (err_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .ptr_o    (ptr_o)
);

// File: tb/lifo_regfile_tb_top.sv
`timescale 1ns/1ps
module lifo_regfile_tb_top;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              rvalid_o, err_o, full_o, empty_o;
    logic [ADDR_W-1:0] ptr_o;

    int n_chk = 0;
    int n_bad = 0;

    int m_mem [DEPTH];
    int m_ptr = 0;
    bit m_full = 1'b0;
    bit m_empty = 1'b1;

    always #2.5 clk = ~clk;

    lifo_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .err_o    (err_o),
        .full_o   (full_o),
        .empty_o  (empty_o),
        .ptr_o    (ptr_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one command, called at a falling edge; checks outputs one edge later
    task automatic op(input bit ps, input bit pp, input int d, input string tag);
        bit lp, lq, e_err;
        int exp_rd;
        lp     = ps && !pp && !m_full;
        lq     = pp && !ps && !m_empty;
        e_err  = (ps && pp) || (ps && !pp && m_full) || (pp && !ps && m_empty);
        exp_rd = 0;
        push_i  = ps;
        pop_i   = pp;
        wdata_i = DATA_W'(d);
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        if (lp) begin
            m_ptr = (m_ptr + 1) % DEPTH;
            m_mem[m_ptr] = d & 255;
            m_full  = (m_ptr == 0);
            m_empty = 1'b0;
        end
        if (lq) begin
            exp_rd  = m_mem[m_ptr];
            m_ptr   = (m_ptr + DEPTH - 1) % DEPTH;
            m_empty = (m_ptr == 0);
            m_full  = 1'b0;
        end
        check(tag, "err", int'(err_o), int'(e_err));
        check(tag, "rvalid", int'(rvalid_o), int'(lq));
        if (lq) check(tag, "rdata", int'(rdata_o), exp_rd);
        check(tag, "ptr", int'(ptr_o), m_ptr);
        check(tag, "full", int'(full_o), int'(m_full));
        check(tag, "empty", int'(empty_o), int'(m_empty));
    endtask

    function automatic int pat(input int i, input int salt);
        return (i * 37 + salt * 11 + 5) & 255;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ptr", int'(ptr_o), 0);
        check("R1", "empty", int'(empty_o), 1);
        check("R1", "full", int'(full_o), 0);
        check("R1", "err", int'(err_o), 0);
        check("R1", "rvalid", int'(rvalid_o), 0);
        rst_ni = 1'b1;
        @(negedge clk);

        op(1'b0, 1'b1, 0, "R7");
        op(1'b1, 1'b1, 99, "R8");
        op(1'b0, 1'b0, 0, "R10");

        // R2 R3: fill to the wrap point, first at 1, last at 0
        for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, pat(i, 0), (i == DEPTH - 1) ? "R3" : "R2");
        op(1'b1, 1'b0, 200, "R6");
        op(1'b1, 1'b1, 201, "R8");
        op(1'b0, 1'b0, 0, "R10");

        // R9 R4 R5: drain fully, data in reverse order
        for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 0, (i == DEPTH - 1) ? "R5" : "R9");
        op(1'b0, 1'b1, 0, "R7");
        op(1'b1, 1'b1, 7, "R8");

        // mixed pattern sweeps with idles
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 5 + r * 3; i++) op(1'b1, 1'b0, pat(i, r + 1), "R2");
            op(1'b0, 1'b0, 0, "R10");
            for (int i = 0; i < 3 + r; i++) op(1'b0, 1'b1, 0, "R4");
            op(1'b1, 1'b1, 3, "R8");
        end
        while (!m_empty) op(1'b0, 1'b1, 0, "R9");

        // R6: refused push must not corrupt the top word
        for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, pat(i, 9), "R2");
        for (int i = 0; i < 4; i++) op(1'b1, 1'b0, 255 - i, "R6");
        for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 0, "R6");
        op(1'b0, 1'b1, 0, "R7");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule